// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block raises the two DMA request lines that let a DMA controller service a UART's receive and transmit FIFOs without processor involvement. On the receive side it watches the FIFO fill level against a programmable trigger threshold. It also runs a small character time-out timer, so that a few characters left below the threshold still get collected. On the transmit side it detects the moment the FIFO stops being full, which means there is room for more data.

Each request is sticky. Once raised, it stays high until the DMA controller pulses the matching clear input. If the raising condition is still present when the clear arrives, the request stays up. A global DMA enable gates both channels; dropping it discards anything pending. The FIFOs, the shift registers and the DMA controller are outside this block and reach it only as level, strobe and flag inputs.

Top module: `uart_dma_req_gen`

## Requirements
- R1: The receive trigger select maps 0, 1, 2, 3 to thresholds of 1, 4, 8 and 14 entries (for the default 16-entry FIFO). With DMA enabled, `rx_req` is high on the clock edge after `rx_level` is equal to or above the selected threshold.
- R2: While `rx_level` is non-zero and neither `rx_push` nor `rx_pop` occurs, `rx_timeout` rises on the clock edge that samples the (4 × `char_bits`)-th `bit_tick` pulse. It then stays high until activity occurs or the FIFO empties.
- R3: With DMA enabled, a high `rx_timeout` raises `rx_req` on the next edge, even when the level is below the threshold.
- R4: A raised `rx_req` stays high until `rx_clr` is sampled high. A clear with no raising condition present drops it on that edge.
- R5: When a clear and a raising condition are sampled in the same cycle, the request remains high. This applies to both channels.
- R6: With DMA enabled, `tx_req` rises on the edge that samples `tx_full` low after it was sampled high on the previous edge. A FIFO that simply stays not-full raises nothing.
- R7: A raised `tx_req` stays high until `tx_clr` is sampled high.
- R8: Any `rx_push` or `rx_pop` restarts the time-out count and lowers `rx_timeout` on the next edge. While `rx_level` is zero the count is held at zero.
- R9: While `dma_en` is low, both requests are low from the next edge onward. A request pending before the disable does not reappear after re-enable unless its condition occurs again.
- R10: A synchronous active-low reset drives `rx_req`, `tx_req` and `rx_timeout` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en | input | 1 | DMA mode enable for both channels |
| rx_trig_sel | input | 2 | Receive trigger threshold select |
| rx_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_push | input | 1 | Strobe: a character was written into the receive FIFO |
| rx_pop | input | 1 | Strobe: a character was read from the receive FIFO |
| bit_tick | input | 1 | One pulse per serial bit time |
| char_bits | input | 4 | Bit times per character frame |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_clr | input | 1 | DMA controller clear for the receive request |
| tx_clr | input | 1 | DMA controller clear for the transmit request |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |
| rx_timeout | output | 1 | Character time-out indication |

## Verification
A miscounted time-out timer moves the rise of `rx_timeout` away from the exact edge that samples the 4 × `char_bits`-th tick. One edge later it shows as a wrong `rx_req`. A sticky-request flop that loses or invents state differs from the expected request on the very next edge, because the bench predicts every request bit on every clock. A stale full-flag history shows up as a missing or spurious `tx_req` one edge after the transmit flag falls or stays low.

// File: rtl/uart_dma_pkg.sv
// Package: shared sizing defaults and the trigger threshold rule.
package uart_dma_pkg;

    localparam int DEF_FIFO_DEPTH = 16;
    localparam int DEF_CHAR_W     = 4;
    localparam int DEF_TO_CHARS   = 4;
    localparam int TRIG_SELS      = 4;

    // Threshold for trigger select `sel` in a FIFO of `depth` entries.
    function automatic int trig_threshold(input int depth, input int sel);
        case (sel)
            0:       return 1;
            1:       return depth / 4;
            2:       return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // Index of each request channel in the request vectors.
    typedef enum int {
        CH_RX = 0,
        CH_TX = 1
    } dma_ch_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/rx_trig_cmp.sv
// Receive trigger comparator.
// Decodes the trigger select into a FIFO threshold and flags when the
// receive occupancy is at or above it. Pure combinational logic.
// Assumes rx_level never exceeds FIFO_DEPTH.
module rx_trig_cmp #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 5,
    parameter int SEL_W      = 2
) (
    input  logic [SEL_W-1:0] trig_sel,
    input  logic [LVL_W-1:0] level,
    output logic             at_trig
);
    localparam int NSEL = 2 ** SEL_W;

    logic [LVL_W-1:0] thr_tab [NSEL];

    // Build the threshold table from the package rule.
    for (genvar gi = 0; gi < NSEL; gi++) begin : g_thr
        assign thr_tab[gi] = LVL_W'(uart_dma_pkg::trig_threshold(FIFO_DEPTH, gi));
    end

    // Compare the occupancy with the selected threshold.
    always_comb begin
        at_trig = (level >= thr_tab[trig_sel]);
    end

endmodule

// File: rtl/rx_char_timer.sv
// Receive character time-out timer.
// Counts bit ticks while the receive FIFO holds data and sees no write or
// read. After TO_CHARS character times it raises a flag. The flag holds
// until the next FIFO activity or until the FIFO empties.
// Assumes char_bits is non-zero; a zero value behaves as a one-tick limit.
module rx_char_timer #(
    parameter int LVL_W    = 5,
    parameter int CHAR_W   = 4,
    parameter int TO_CHARS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level,
    input  logic              push,
    input  logic              pop,
    input  logic              bit_tick,
    input  logic [CHAR_W-1:0] char_bits,
    output logic              timeout
);
    localparam int CNT_W = CHAR_W + $clog2(TO_CHARS + 1);

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] last_cnt;
    logic             restart;
    logic             flag_q;

    // Time-out length in bit ticks and the count value that completes it.
    always_comb begin
        limit    = CNT_W'(char_bits) * CNT_W'(TO_CHARS);
        last_cnt = (limit == '0) ? '0 : limit - CNT_W'(1);
        restart  = (level == '0) || push || pop;
    end

    // Tick counter and sticky time-out flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            flag_q   <= 1'b0;
        end else if (restart) begin
            tick_cnt <= '0;
            flag_q   <= 1'b0;
        end else if (bit_tick && !flag_q) begin
            if (tick_cnt >= last_cnt) begin
                tick_cnt <= '0;
                flag_q   <= 1'b1;
            end else begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
        end
    end

    assign timeout = flag_q;

    p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> !timeout);

    p_activity_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push || pop) |=> !timeout);

    p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt <= last_cnt));

endmodule

// File: rtl/tx_space_detect.sv
// Transmit space detector.
// Registers the transmit full flag and reports the cycle in which it is
// sampled low right after being sampled high (full to not-full).
// Assumes tx_full is synchronous to clk.
module tx_space_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_full,
    output logic space_evt
);
    logic full_q;

    // Remember last cycle's full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else begin
            full_q <= tx_full;
        end
    end

    // Transition from full to not-full.
    always_comb begin
        space_evt = full_q && !tx_full;
    end

    p_evt_not_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        space_evt |-> !tx_full);

endmodule

// File: rtl/dma_req_hold.sv
// Sticky DMA request flop.
// Raises the request when its set condition is seen with the channel enabled.
// Holds it until the controller clears it; set wins over a simultaneous
// clear. A low enable drops the request and discards it.
module dma_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic req
);
    logic req_q;

    // Request state: set-dominant, cleared by controller, killed by disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (!enable) begin
            req_q <= 1'b0;
        end else if (set) begin
            req_q <= 1'b1;
        end else if (clr) begin
            req_q <= 1'b0;
        end
    end

    assign req = req_q;

    p_hold_until_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && req && !clr) |=> req);

    p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set && clr) |=> req);

    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && clr && !set) |=> !req);

    p_disable_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !req);

endmodule

// File: rtl/uart_dma_req_gen.sv
// UART FIFO DMA request generator (top).
// Combines the receive trigger comparator, the character time-out timer and
// the transmit space detector. Each resulting raise condition feeds its own
// sticky request flop.
// Assumes all inputs are synchronous to clk and clears are single strobes
// from the DMA controller.
module uart_dma_req_gen #(
    parameter int FIFO_DEPTH = uart_dma_pkg::DEF_FIFO_DEPTH,
    parameter int CHAR_W     = uart_dma_pkg::DEF_CHAR_W,
    parameter int TO_CHARS   = uart_dma_pkg::DEF_TO_CHARS,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int SEL_W     = $clog2(uart_dma_pkg::TRIG_SELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic [SEL_W-1:0]  rx_trig_sel,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              bit_tick,
    input  logic [CHAR_W-1:0] char_bits,
    input  logic              tx_full,
    input  logic              rx_clr,
    input  logic              tx_clr,
    output logic              rx_req,
    output logic              tx_req,
    output logic              rx_timeout
);
    import uart_dma_pkg::*;

    logic              rx_at_trig;
    logic              to_flag;
    logic              tx_space;
    logic [NUM_CH-1:0] set_vec;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] req_vec;

    rx_trig_cmp #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W),
        .SEL_W      (SEL_W)
    ) u_trig (
        .trig_sel (rx_trig_sel),
        .level    (rx_level),
        .at_trig  (rx_at_trig)
    );

    rx_char_timer #(
        .LVL_W    (LVL_W),
        .CHAR_W   (CHAR_W),
        .TO_CHARS (TO_CHARS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (rx_level),
        .push      (rx_push),
        .pop       (rx_pop),
        .bit_tick  (bit_tick),
        .char_bits (char_bits),
        .timeout   (to_flag)
    );

    tx_space_detect u_txdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_full   (tx_full),
        .space_evt (tx_space)
    );

    // Route each channel's raise condition and clear strobe.
    always_comb begin
        set_vec        = '0;
        clr_vec        = '0;
        set_vec[CH_RX] = rx_at_trig || to_flag;
        set_vec[CH_TX] = tx_space;
        clr_vec[CH_RX] = rx_clr;
        clr_vec[CH_TX] = tx_clr;
    end

    // One sticky request flop per channel.
    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
        dma_req_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (dma_en),
            .set    (set_vec[gc]),
            .clr    (clr_vec[gc]),
            .req    (req_vec[gc])
        );
    end

    assign rx_req     = req_vec[CH_RX];
    assign tx_req     = req_vec[CH_TX];
    assign rx_timeout = to_flag;

    p_trig_raises_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && rx_at_trig) |=> rx_req);

    p_timeout_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && to_flag) |=> rx_req);

    p_tx_space_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && tx_space) |=> tx_req);

    p_tx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_req && !tx_space) |=> !tx_req);

    p_both_low_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> (!rx_req && !tx_req));

endmodule

// File: tb/uart_dma_req_gen_test.sv
module uart_dma_req_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 1'b0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic [4:0] rx_level = 5'd0;
    logic       rx_push = 1'b0;
    logic       rx_pop = 1'b0;
    logic       bit_tick = 1'b0;
    logic [3:0] char_bits = 4'd8;
    logic       tx_full = 1'b0;
    logic       rx_clr = 1'b0;
    logic       tx_clr = 1'b0;
    logic       rx_req, tx_req, rx_timeout;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R10";

    // Reference model state.
    int ticks = 0;
    bit m_to = 0, m_rx = 0, m_tx = 0, m_prev_full = 0;

    uart_dma_req_gen uut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .rx_trig_sel(rx_trig_sel),
        .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .char_bits(char_bits), .tx_full(tx_full), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .rx_req(rx_req), .tx_req(tx_req), .rx_timeout(rx_timeout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int thr_of(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    // Behavioural model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        bit rx_set, tx_set;
        if (!rst_n) begin
            ticks = 0; m_to = 0; m_rx = 0; m_tx = 0; m_prev_full = 0;
        end else begin
            rx_set = (int'(rx_level) >= thr_of(rx_trig_sel)) || m_to;
            tx_set = m_prev_full && !tx_full;
            m_rx = dma_en && (rx_set || (m_rx && !rx_clr));
            m_tx = dma_en && (tx_set || (m_tx && !tx_clr));
            m_prev_full = tx_full;
            if (rx_level == 0 || rx_push || rx_pop) ticks = 0;
            else if (bit_tick && ticks < 4 * int'(char_bits)) ticks++;
            m_to = (rx_level != 0) && !rx_push && !rx_pop && (ticks >= 4 * int'(char_bits));
        end
    end

    // Compare every output with the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rx_req !== m_rx || tx_req !== m_tx || rx_timeout !== m_to) begin
                failures++;
                $display("FAIL %s per-cycle: act rx=%0b tx=%0b to=%0b exp rx=%0b tx=%0b to=%0b",
                         cur_req, rx_req, tx_req, rx_timeout, m_rx, m_tx, m_to);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog: act cycles=%0d exp below %0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: act=%0b exp=%0b", req, what, act, exp);
        end
    endtask

    task automatic pulse_rx_clr();
        rx_clr = 1'b1; cyc(1); rx_clr = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R10", "rx_req after reset", rx_req, 1'b0);
        chk("R10", "tx_req after reset", tx_req, 1'b0);
        chk("R10", "rx_timeout after reset", rx_timeout, 1'b0);

        // R1: every trigger select, just below and at the threshold.
        cur_req = "R1";
        dma_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            rx_level = 5'(thr_of(s) - 1);
            cyc(2);
            chk("R1", $sformatf("below threshold sel=%0d", s), rx_req, 1'b0);
            rx_level = 5'(thr_of(s));
            cyc(1);
            chk("R1", $sformatf("at threshold sel=%0d", s), rx_req, 1'b1);
            rx_level = 5'd0;
            pulse_rx_clr();
            cyc(1);
        end

        // R4: request held with condition gone, then cleared.
        cur_req = "R4";
        rx_trig_sel = 2'd2;
        rx_level = 5'd8; cyc(1);
        rx_level = 5'd2; cyc(3);
        chk("R4", "held without clear", rx_req, 1'b1);
        pulse_rx_clr();
        chk("R4", "dropped by clear", rx_req, 1'b0);

        // R5: clear while the threshold still holds.
        cur_req = "R5";
        rx_level = 5'd9; cyc(1);
        pulse_rx_clr();
        chk("R5", "rx clear with set pending", rx_req, 1'b1);
        rx_level = 5'd0; pulse_rx_clr(); cyc(1);

        // R2 and R3: time-out after 4 x 8 ticks below threshold.
        cur_req = "R2";
        rx_trig_sel = 2'd3; char_bits = 4'd8;
        rx_level = 5'd1; bit_tick = 1'b1;
        cyc(31);
        chk("R2", "no timeout after 31 ticks", rx_timeout, 1'b0);
        cyc(1);
        chk("R2", "timeout after 32 ticks", rx_timeout, 1'b1);
        cur_req = "R3";
        cyc(1);
        chk("R3", "timeout raises rx_req", rx_req, 1'b1);

        // R8: activity restarts, empty holds the count.
        cur_req = "R8";
        rx_push = 1'b1; cyc(1); rx_push = 1'b0;
        chk("R8", "push clears timeout", rx_timeout, 1'b0);
        cyc(20);
        rx_pop = 1'b1; cyc(1); rx_pop = 1'b0;
        cyc(25);
        chk("R8", "pop restarted count", rx_timeout, 1'b0);
        rx_level = 5'd0; cyc(40);
        chk("R8", "empty holds count", rx_timeout, 1'b0);
        rx_level = 5'd1; cyc(31);
        chk("R8", "count starts from zero after empty", rx_timeout, 1'b0);
        rx_level = 5'd0; bit_tick = 1'b0;
        pulse_rx_clr(); cyc(1);
        chk("R4", "rx clear after timeout phase", rx_req, 1'b0);

        // R6 and R7: transmit edge detection and hold.
        cur_req = "R6";
        cyc(4);
        chk("R6", "not-full level raises nothing", tx_req, 1'b0);
        tx_full = 1'b1; cyc(2);
        chk("R6", "full raises nothing", tx_req, 1'b0);
        tx_full = 1'b0; cyc(1);
        chk("R6", "full to not-full raises", tx_req, 1'b1);
        cur_req = "R7";
        cyc(3);
        chk("R7", "tx held", tx_req, 1'b1);
        tx_clr = 1'b1; cyc(1); tx_clr = 1'b0;
        chk("R7", "tx cleared", tx_req, 1'b0);
        cyc(3);
        chk("R7", "tx stays low", tx_req, 1'b0);
        cur_req = "R5";
        tx_full = 1'b1; cyc(1);
        tx_full = 1'b0; tx_clr = 1'b1; cyc(1); tx_clr = 1'b0;
        chk("R5", "tx clear with edge same cycle", tx_req, 1'b1);
        tx_clr = 1'b1; cyc(1); tx_clr = 1'b0;

        // R9: disable discards pending requests.
        cur_req = "R9";
        rx_level = 5'd14; cyc(1);
        tx_full = 1'b1; cyc(1); tx_full = 1'b0; cyc(1);
        chk("R9", "rx pending before disable", rx_req, 1'b1);
        dma_en = 1'b0; cyc(1);
        chk("R9", "rx low when disabled", rx_req, 1'b0);
        chk("R9", "tx low when disabled", tx_req, 1'b0);
        rx_level = 5'd0;
        tx_full = 1'b1; cyc(1); tx_full = 1'b0; cyc(1);
        dma_en = 1'b1; cyc(2);
        chk("R9", "rx not restored", rx_req, 1'b0);
        chk("R9", "tx not restored", tx_req, 1'b0);

        // Mixed random traffic checked against the model every cycle.
        cur_req = "R1/R2/R4/R6";
        for (int k = 0; k < 3000; k++) begin
            rx_level    = 5'($urandom_range(0, 16));
            if ($urandom_range(0, 3) != 0 && k % 64 > 8) rx_level = 5'd1;
            rx_trig_sel = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'd3;
            rx_push     = ($urandom_range(0, 40) == 0);
            rx_pop      = ($urandom_range(0, 40) == 0);
            bit_tick    = ($urandom_range(0, 1) == 1);
            char_bits   = (k % 500 == 0) ? 4'($urandom_range(5, 12)) : char_bits;
            tx_full     = ($urandom_range(0, 2) == 0);
            rx_clr      = ($urandom_range(0, 5) == 0);
            tx_clr      = ($urandom_range(0, 5) == 0);
            dma_en      = ($urandom_range(0, 60) != 0);
            cyc(1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule